// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block turns single-word host requests into strobe sequences for a 4-bit-wide asynchronous EDO DRAM with a multiplexed address bus. A host offers an access with a valid/ready handshake carrying a row-and-column address, a write flag and write data. The controller opens the row by dropping the row strobe with the row half of the address on the pins, then runs a column cycle with the column half. Reads return one word with a one-cycle valid pulse. Writes are early writes: write enable is low before the column strobe falls.

After an access the row is left open. A later request to the same row runs as an EDO page cycle, in which only the column strobe pulses. A request to another row closes the open row, waits out precharge and activates the new row. The row is also closed before it has been open too long, and when an external refresh sequencer asks for the memory. The refresh grant is given only when the controller is idle with the row closed and precharged. Every analog timing limit is a nanosecond parameter rounded up to whole controller clock cycles.

Top module: `edo_page_ctrl`

## Requirements
- R1: During and right after reset, all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `dram_dq_oe` is low, and `rd_valid` and `ref_grant` are low.
- R2: A read runs with write enable high and output enable low at the column strobe fall. The column strobe falls no sooner than max(2, ceil(T_RCD_NS/CLK_NS)) cycles after the row strobe, and only while the row strobe is low. The word on `dram_dq_i` is returned on `rd_data` with `rd_valid` high for exactly one cycle.
- R3: A write drives `dram_we_n` low and `dram_dq_oe` high with the data at least one cycle before the column strobe falls, keeps output enable high, and produces no `rd_valid` pulse.
- R4: The host address is {row, column}, with the row in bits [21:11] and the column in bits [10:0]. The row sits on `dram_addr` when the row strobe falls, and the column sits there when the column strobe falls.
- R5: A request to the currently open row runs as a page cycle: the column strobe pulses and the row strobe does not toggle.
- R6: A request to a different row raises the row strobe, which stays high at least ceil(T_RP_NS/CLK_NS) cycles before the next fall.
- R7: The column strobe stays high at least ceil(T_CP_NS/CLK_NS) cycles between column cycles. Each row strobe low period lasts at least max(ceil(T_RAS_NS/CLK_NS), ceil(T_RC_NS/CLK_NS) - ceil(T_RP_NS/CLK_NS)) cycles.
- R8: The row strobe is never low for more than ceil(T_RAS_MAX_NS/CLK_NS) cycles. An endless stream of hits to one row still sees the row closed and reopened.
- R9: A refresh request closes any open row, and after precharge `ref_grant` rises. While granted, all strobes stay high, `dram_dq_oe` is low and `req_ready` is low. After `ref_req` drops, precharge is honoured again before the next activation.
- R10: `rd_data` keeps the last word read until the next `rd_valid`, including across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Request is taken at this clock edge |
| req_addr | input | 22 | {row, column} word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle pulse, read word on rd_data |
| rd_data | output | 4 | Last read word |
| ref_req | input | 1 | Refresh sequencer asks for the memory |
| ref_grant | output | 1 | Memory idle, closed and precharged for refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_o | output | 4 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 4 | Data from the DRAM |

## Verification
The bench drives a behavioural DRAM that latches row and column on the strobe falls and holds read data after the column strobe rises. Against it the bench runs an isolated read to a closed row, write-then-read pairs inside one open row, and a jump to a second row. These separate page hits, which must leave the row strobe untouched, from misses, which must show a full precharge gap. A long stream of hits to a single row shows that the row-open limit closes the row even when no miss ever arrives. A refresh request arriving with a row open shows the close, precharge and grant order, and that requests are held off while the grant is high. A monitor records the shortest precharge, RAS-to-CAS and CAS-high gaps and the longest row-open period over the whole run.

// File: rtl/edo_page_ctrl.sv
`timescale 1ns/1ps
module edo_page_ctrl #(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int DQ_W         = 4,
  parameter int CLK_NS       = 10,
  parameter int T_RCD_NS     = 12,
  parameter int T_CAC_NS     = 15,
  parameter int T_CP_NS      = 10,
  parameter int T_RP_NS      = 30,
  parameter int T_RAS_NS     = 50,
  parameter int T_RC_NS      = 84,
  parameter int T_RAS_MAX_NS = 10000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_write,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rd_valid,
  output logic [DQ_W-1:0]        rd_data,
  input  logic                   ref_req,
  output logic                   ref_grant,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DQ_W-1:0]        dram_dq_o,
  output logic                   dram_dq_oe,
  input  logic [DQ_W-1:0]        dram_dq_i
);

  function automatic int to_cyc(input int ns, input int floor_c);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < floor_c) ? floor_c : c;
  endfunction

  localparam int RCD_C   = to_cyc(T_RCD_NS, 2);
  localparam int CAC_C   = to_cyc(T_CAC_NS, 1);
  localparam int CP_C    = to_cyc(T_CP_NS, 1);
  localparam int RP_C    = to_cyc(T_RP_NS, 1);
  localparam int RAS_C   = to_cyc(T_RAS_NS, 1);
  localparam int RC_C    = to_cyc(T_RC_NS, 1);
  localparam int RLOW_C  = (RAS_C > RC_C - RP_C) ? RAS_C : RC_C - RP_C;
  localparam int RMAX_C  = to_cyc(T_RAS_MAX_NS, 1);
  localparam int PAGE_C  = CAC_C + CP_C + 2;
  localparam int LIMIT_C = RMAX_C - PAGE_C - 1;
  localparam int CW      = $clog2(RMAX_C + 2);

  localparam logic [CW-1:0] ONE_V   = CW'(1);
  localparam logic [CW-1:0] RCD_V   = CW'(RCD_C);
  localparam logic [CW-1:0] CAC_V   = CW'(CAC_C);
  localparam logic [CW-1:0] CP_V    = CW'(CP_C);
  localparam logic [CW-1:0] RP_V    = CW'(RP_C);
  localparam logic [CW-1:0] RLOW_V  = CW'(RLOW_C);
  localparam logic [CW-1:0] RMAX_V  = CW'(RMAX_C);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT_C);
  localparam logic [CW-1:0] CLOSE_V = CW'(RLOW_C - 1);

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_COL, S_CASL, S_CASH, S_PRE, S_REF} state_t;

  state_t            state;
  logic [CW-1:0]     cnt, ras_cnt;
  logic              row_open, cur_wr;
  logic [ROW_W-1:0]  open_row;
  logic [COL_W-1:0]  cur_col;
  logic              ras_n, cas_n, we_n, oe_n, dq_oe, rdv;
  logic [ROW_W-1:0]  addr_q;
  logic [DQ_W-1:0]   dq_q, rdd;

  wire [ROW_W-1:0] req_row   = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] req_col   = req_addr[COL_W-1:0];
  wire             hit       = row_open && (req_row == open_row);
  wire             can_close = ras_cnt >= CLOSE_V;
  wire             aged      = ras_cnt >= LIMIT_V;
  wire             close_now = row_open && can_close &&
                               (ref_req || aged || (req_valid && !hit));

  assign req_ready  = (state == S_IDLE) && !ref_req && (!row_open || (hit && !aged));
  assign ref_grant  = (state == S_REF);
  assign dram_ras_n = ras_n;
  assign dram_cas_n = cas_n;
  assign dram_we_n  = we_n;
  assign dram_oe_n  = oe_n;
  assign dram_addr  = addr_q;
  assign dram_dq_o  = dq_q;
  assign dram_dq_oe = dq_oe;
  assign rd_valid   = rdv;
  assign rd_data    = rdd;

  always_ff @(posedge clk) begin
    if (!rst_n) ras_cnt <= '0;
    else if (ras_n) ras_cnt <= '0;
    else if (ras_cnt != '1) ras_cnt <= ras_cnt + ONE_V;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      row_open <= 1'b0;
      open_row <= '0;
      cur_col  <= '0;
      cur_wr   <= 1'b0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      dq_oe    <= 1'b0;
      addr_q   <= '0;
      dq_q     <= '0;
      rdv      <= 1'b0;
      rdd      <= '0;
    end else begin
      rdv <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            cur_col <= req_col;
            cur_wr  <= req_write;
            we_n    <= !req_write;
            oe_n    <= req_write;
            dq_q    <= req_wdata;
            dq_oe   <= req_write;
            cnt     <= ONE_V;
            if (row_open) begin
              addr_q <= ROW_W'(req_col);
              state  <= S_COL;
            end else begin
              ras_n    <= 1'b0;
              addr_q   <= req_row;
              open_row <= req_row;
              row_open <= 1'b1;
              state    <= S_RCD;
            end
          end else if (close_now) begin
            ras_n    <= 1'b1;
            row_open <= 1'b0;
            cnt      <= ONE_V;
            state    <= S_PRE;
          end else if (ref_req && !row_open) begin
            state <= S_REF;
          end
        end
        S_RCD: begin
          if (cnt == ONE_V) addr_q <= ROW_W'(cur_col);
          if (cnt == RCD_V) begin
            cas_n <= 1'b0;
            cnt   <= ONE_V;
            state <= S_CASL;
          end else begin
            cnt <= cnt + ONE_V;
          end
        end
        S_COL: begin
          cas_n <= 1'b0;
          cnt   <= ONE_V;
          state <= S_CASL;
        end
        S_CASL: begin
          if (cnt == CAC_V) begin
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            if (!cur_wr) begin
              rdv <= 1'b1;
              rdd <= dram_dq_i;
            end
            cnt   <= ONE_V;
            state <= S_CASH;
          end else begin
            cnt <= cnt + ONE_V;
          end
        end
        S_CASH: begin
          if (cnt == CP_V) state <= S_IDLE;
          else cnt <= cnt + ONE_V;
        end
        S_PRE: begin
          if (cnt == RP_V) state <= S_IDLE;
          else cnt <= cnt + ONE_V;
        end
        S_REF: begin
          if (!ref_req) begin
            cnt   <= ONE_V;
            state <= S_PRE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] hi_run, lo_run, chi_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run  <= RP_V;
      lo_run  <= '0;
      chi_run <= CP_V;
    end else begin
      hi_run  <= ras_n ? ((hi_run < RP_V) ? hi_run + ONE_V : hi_run) : '0;
      lo_run  <= !ras_n ? ((lo_run != '1) ? lo_run + ONE_V : lo_run) : '0;
      chi_run <= cas_n ? ((chi_run < CP_V) ? chi_run + ONE_V : chi_run) : '0;
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);  // R2
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);  // R2
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && dram_dq_oe && dram_oe_n));  // R3
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_run >= RP_V));  // R6
  AST_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (chi_run >= CP_V));  // R7
  AST_ROW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (lo_run >= RLOW_V));  // R7
  AST_ROW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (lo_run < RMAX_V));  // R8
  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> (dram_ras_n && dram_cas_n && !dram_dq_oe && !req_ready));  // R9

endmodule

// File: tb/edo_page_ctrl_tb.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 11;
  localparam int COL_W = 11;
  localparam int DQ_W  = 4;

  localparam int RP_X   = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RCD_R  = (12 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RCD_X  = (RCD_R < 2) ? 2 : RCD_R;
  localparam int CP_X   = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RAS_X  = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RC_X   = (84 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RLOW_X = (RAS_X > RC_X - RP_X) ? RAS_X : RC_X - RP_X;
  localparam int RMAX_X = (10000 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DQ_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ref_grant;
  logic [DQ_W-1:0] rd_data;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [ROW_W-1:0] dram_addr;
  logic [DQ_W-1:0] dq_o;
  logic [DQ_W-1:0] dq_i = '0;

  edo_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .CLK_NS(CLK_PERIOD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_grant(ref_grant),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(dram_addr), .dram_dq_o(dq_o), .dram_dq_oe(dq_oe), .dram_dq_i(dq_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  logic [DQ_W-1:0] dmem [int];
  logic [DQ_W-1:0] shadow [int];

  function automatic logic [DQ_W-1:0] bg(input int a);
    return DQ_W'(a) ^ DQ_W'(a >> 11) ^ DQ_W'(a >> 18);
  endfunction

  function automatic logic [DQ_W-1:0] expect_of(input int a);
    return shadow.exists(a) ? shadow[a] : bg(a);
  endfunction

  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  bit seen_rise = 0, seen_crise = 0, rcd_act = 0;
  int hi_run = 0, lo_run = 0, chi_run = 0, rcd_run = 0;
  int min_rp = 9999, min_low = 99999, max_low = 0, min_rcd = 9999, min_cp = 9999;
  int ras_falls = 0, ras_rises = 0, we_late = 0, cas_wo_ras = 0, oe_bad = 0, rdv_cnt = 0;
  logic [ROW_W-1:0] lat_row = '0;
  logic [COL_W-1:0] lat_col = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) rdv_cnt++;
      rcd_run++;
      if (!ras_n && prev_ras) begin
        ras_falls++;
        if (seen_rise && hi_run < min_rp) min_rp = hi_run;
        lat_row = dram_addr;
        lo_run = 1; rcd_run = 0; rcd_act = 1;
      end else if (ras_n && !prev_ras) begin
        ras_rises++; seen_rise = 1;
        if (lo_run < min_low) min_low = lo_run;
        if (lo_run > max_low) max_low = lo_run;
        hi_run = 1;
      end else if (ras_n) hi_run++;
      else begin
        lo_run++;
        if (lo_run > max_low) max_low = lo_run;
      end
      if (!cas_n && prev_cas) begin
        int key;
        if (ras_n) cas_wo_ras++;
        if (rcd_act) begin
          if (rcd_run < min_rcd) min_rcd = rcd_run;
          rcd_act = 0;
        end
        if (seen_crise && chi_run < min_cp) min_cp = chi_run;
        lat_col = dram_addr[COL_W-1:0];
        key = int'({lat_row, lat_col});
        if (!we_n) begin
          if (prev_we) we_late++;
          if (!oe_n || !dq_oe) oe_bad++;
          dmem[key] = dq_o;
        end else begin
          if (oe_n) oe_bad++;
          dq_i = dmem.exists(key) ? dmem[key] : bg(key);
        end
      end else if (cas_n && !prev_cas) begin
        seen_crise = 1; chi_run = 1;
      end else if (cas_n) chi_run++;
      prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n;
    end
  end

  task automatic send(input int a, input bit wr, input logic [DQ_W-1:0] d);
    int w;
    @(negedge clk);
    req_addr = (ROW_W+COL_W)'(a); req_write = wr; req_wdata = d; req_valid = 1'b1;
    #1;
    w = 0;
    while (!req_ready && w < 400) begin
      @(negedge clk); #1; w++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) shadow[a] = d;
  endtask

  task automatic do_read(input int a, output logic [DQ_W-1:0] d, output bit pulse_ok);
    int w;
    int rdv0;
    rdv0 = rdv_cnt;
    send(a, 1'b0, '0);
    w = 0;
    while (!rd_valid && w < 40) begin
      @(negedge clk); w++;
    end
    d = rd_data;
    @(negedge clk);
    pulse_ok = (w < 40) && !rd_valid && (rdv_cnt == rdv0 + 1);
  endtask

  function automatic int mk(input int row, input int col);
    return (row << COL_W) | col;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && we_n && oe_n, "R1 strobes high in reset", {ras_n, cas_n, we_n, oe_n}, 15);
    check(!dq_oe && !rd_valid && !ref_grant, "R1 outputs idle in reset", {dq_oe, rd_valid, ref_grant}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(ras_n && cas_n && !dq_oe && !ref_grant, "R1 idle after reset", {ras_n, cas_n, dq_oe, ref_grant}, 12);
  endtask

  task automatic t_read_miss();
    logic [DQ_W-1:0] d; bit p; int a;
    a = mk(37, 5);
    do_read(a, d, p);
    check(d == expect_of(a), "R2 read miss data", d, expect_of(a));
    check(p, "R2 rd_valid one-cycle pulse", p, 1);
    check(lat_row == 11'd37, "R4 row on pins at row strobe", lat_row, 37);
    check(lat_col == 11'd5, "R4 column on pins at column strobe", lat_col, 5);
    check(ras_falls == 1, "R2 single activation", ras_falls, 1);
  endtask

  task automatic t_write_hit();
    logic [DQ_W-1:0] d; bit p; int rdv0, f0;
    rdv0 = rdv_cnt; f0 = ras_falls;
    send(mk(37, 9), 1'b1, 4'hA);
    repeat (8) @(negedge clk);
    check(rdv_cnt == rdv0, "R3 write gives no rd_valid", rdv_cnt - rdv0, 0);
    check(dmem.exists(mk(37, 9)) && dmem[mk(37, 9)] == 4'hA, "R3 early write stored",
          dmem.exists(mk(37, 9)) ? int'(dmem[mk(37, 9)]) : -1, 10);
    do_read(mk(37, 9), d, p);
    check(d == 4'hA && p, "R3 read back after write", d, 10);
    check(ras_falls == f0, "R5 hit keeps row strobe low", ras_falls - f0, 0);
  endtask

  task automatic t_page_burst();
    logic [DQ_W-1:0] d; bit p; int f0, bad;
    f0 = ras_falls; bad = 0;
    for (int i = 0; i < 6; i++) begin
      send(mk(37, 100 + i), 1'b1, DQ_W'(i * 3 + 1));
      do_read(mk(37, 100 + i), d, p);
      if (d != DQ_W'(i * 3 + 1) || !p) bad++;
    end
    check(bad == 0, "R5 page burst data", bad, 0);
    check(ras_falls == f0, "R5 page burst no row toggle", ras_falls - f0, 0);
  endtask

  task automatic t_edo_hold();
    logic [DQ_W-1:0] d; bit p;
    do_read(mk(37, 200), d, p);
    send(mk(37, 201), 1'b1, ~d);
    repeat (6) @(negedge clk);
    check(rd_data == d, "R10 rd_data held across write", rd_data, d);
  endtask

  task automatic t_row_miss();
    logic [DQ_W-1:0] d; bit p; int f0, r0;
    f0 = ras_falls; r0 = ras_rises;
    do_read(mk(1500, 77), d, p);
    check(d == expect_of(mk(1500, 77)) && p, "R6 miss read data", d, expect_of(mk(1500, 77)));
    check(ras_rises == r0 + 1 && ras_falls == f0 + 1, "R6 row closed and reopened",
          ras_falls - f0, 1);
    check(min_rp >= RP_X, "R6 precharge gap", min_rp, RP_X);
    check(lat_row == 11'd1500, "R4 new row latched", lat_row, 1500);
  endtask

  task automatic t_refresh();
    logic [DQ_W-1:0] d; bit p; int r0, w, bad;
    do_read(mk(900, 3), d, p);
    r0 = ras_rises;
    @(negedge clk); ref_req = 1'b1;
    w = 0;
    while (!ref_grant && w < 60) begin @(negedge clk); w++; end
    check(ref_grant, "R9 grant given", ref_grant, 1);
    check(ras_rises == r0 + 1 && ras_n, "R9 open row closed first", ras_rises - r0, 1);
    check(w >= RP_X, "R9 grant after precharge", w, RP_X);
    req_addr = (ROW_W+COL_W)'(mk(900, 4)); req_write = 1'b0; req_valid = 1'b1;
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (req_ready || !ras_n || !cas_n || dq_oe || !ref_grant) bad++;
    end
    req_valid = 1'b0;
    check(bad == 0, "R9 quiet and blocked while granted", bad, 0);
    ref_req = 1'b0;
    do_read(mk(900, 4), d, p);
    check(d == expect_of(mk(900, 4)) && p, "R9 access after refresh", d, expect_of(mk(900, 4)));
    check(min_rp >= RP_X, "R9 precharge kept after grant", min_rp, RP_X);
  endtask

  task automatic t_row_limit();
    logic [DQ_W-1:0] d; bit p; int r0, bad;
    r0 = ras_rises; bad = 0;
    for (int i = 0; i < 260; i++) begin
      do_read(mk(444, i % 64), d, p);
      if (d != expect_of(mk(444, i % 64)) || !p) bad++;
    end
    check(bad == 0, "R8 hit stream data", bad, 0);
    check(ras_rises > r0, "R8 aged row closed", ras_rises - r0, 1);
    check(max_low <= RMAX_X, "R8 row-open limit", max_low, RMAX_X);
  endtask

  task automatic t_timing();
    check(min_rcd >= RCD_X, "R2 row-to-column delay", min_rcd, RCD_X);
    check(cas_wo_ras == 0, "R2 column strobe only under row strobe", cas_wo_ras, 0);
    check(we_late == 0, "R3 write enable before column strobe", we_late, 0);
    check(oe_bad == 0, "R2 output enable per access type", oe_bad, 0);
    check(min_cp >= CP_X, "R7 column strobe high time", min_cp, CP_X);
    check(min_low >= RLOW_X, "R7 row strobe low time", min_low, RLOW_X);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_read_miss();
    t_write_hit();
    t_page_burst();
    t_edo_hold();
    t_row_miss();
    t_refresh();
    t_row_limit();
    t_timing();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule